// File: doc/BRIEF.md
# Video Line and Field Reference Generator

This block produces the horizontal reference (HREF), the vertical reference (VREF) and the active-video qualifier (VACT) for a pixel interface. All timing is counted in cycles of one pixel clock, nominally 13.5 MHz. A standard-select input chooses between 625-line/50 Hz timing and 525-line/60 Hz timing. This choice sets the line period, the field lengths and the number of active lines.

The generator can run freely from its own pixel and line counters. It can also follow line-start and field-start strobes that come from an upstream sync decoder. In the following mode, a strobe corrects the counters only when it falls inside a tolerance window around the expected position. A strobe outside the window is discarded. Erratic input therefore cannot stretch or shrink the reference periods beyond that window.

HREF is inactive for a fixed gap at the start of every line. VREF starts on the first line of each field and lasts a programmable number of lines. Each of HREF and VREF has its own inversion control.

Top module: `vtg_timing_gen`

## Requirements
- R1: While `rst` is high, `href`, `vref` and `vact` are all 0. After reset, the counters start at pixel 0 of line 0 of the long field.
- R2: The line period is `LINE_A` clocks (864 by default) when `std_sel`=0 (625-line) and `LINE_B` clocks (858 by default) when `std_sel`=1 (525-line). Within each line, HREF is inactive for pixels 0 to `HGAP`-1 (`HGAP`=64 by default) and active for the rest of the line.
- R3: Fields alternate between a long field and a short field, starting with the long field after reset. The long field has `FLD_A` lines (313) and the short field 312 when `std_sel`=0. The long field has `FLD_B` lines (263) and the short field 262 when `std_sel`=1. If the standard changes while a counter is past the new limit, that counter wraps at its next step.
- R4: VREF is active on lines 0 to L-1 of every field, where L is the programmed `vlen` value.
- R5: L is `vlen` clamped to the range 2..9: values 0 and 1 act as 2, and values 10 to 15 act as 9.
- R6: VACT is 1 only while HREF is active and the line index lies in [`ACT_FIRST`, `ACT_FIRST`+N). N is `ACT_A` (288) for the 625-line standard and `ACT_B` (240) for the 525-line standard.
- R7: Each output is registered and reflects the counter state one clock earlier. `hpol`=1 inverts HREF and `vpol`=1 inverts VREF, each after the same one-clock register stage. VACT is never inverted.
- R8: With `sync_en`=1, a `line_stb` seen while the pixel index p satisfies p<=`HWIN` or p>=line period−`HWIN` sets the pixel index to 1 on the next clock. When p>=line period−`HWIN` (an early strobe), the line index also advances, exactly as it would at a normal line end.
- R9: A `line_stb` outside that window, or any `line_stb` while `sync_en`=0, has no effect on the timing.
- R10: With `sync_en`=1, an `fld_stb` seen while the line index v satisfies v>=field length−`VWIN` or v<`VWIN` is held until the next line end. At that line end the line index becomes 0. The field parity toggles only if v>=`VWIN` at that point. An `fld_stb` seen at any other line index is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| std_sel | input | 1 | 0 = 625-line/50 Hz, 1 = 525-line/60 Hz |
| sync_en | input | 1 | 1 = follow input strobes, 0 = free run |
| line_stb | input | 1 | Line-start strobe from the sync decoder |
| fld_stb | input | 1 | Field-start strobe from the sync decoder |
| vlen | input | 4 | Requested VREF length in lines |
| hpol | input | 1 | Invert HREF when 1 |
| vpol | input | 1 | Invert VREF when 1 |
| href | output | 1 | Horizontal reference |
| vref | output | 1 | Vertical reference |
| vact | output | 1 | Active-video qualifier |

## Verification
Every output is due exactly one clock after the counter state and the control inputs that produce it. A strobe accepted on one edge shows its effect on the outputs one edge later. A field strobe acts at the next line end, so its effect on VREF appears one clock after that edge.

The bench runs a behavioural model of the counters that advances on the same edge as the design and latches its expected outputs from its state before the update. It compares all three outputs at the falling edge of every clock, which keeps each comparison clear of the edge that changes them. Strobes are placed at chosen pixel and line positions by reading the model's own state, so that window edges and positions one step outside them are hit exactly.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    typedef enum logic {
        STD_625 = 1'b0,
        STD_525 = 1'b1
    } vtg_std_e;

    typedef struct packed {
        logic href;
        logic vref;
        logic vact;
    } vtg_ref_t;

    localparam logic [3:0] VLEN_MIN = 4'd2;
    localparam logic [3:0] VLEN_MAX = 4'd9;

    function automatic int vtg_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [3:0] vtg_vlen_clamp(input logic [3:0] req);
        if (req < VLEN_MIN)      return VLEN_MIN;
        else if (req > VLEN_MAX) return VLEN_MAX;
        else                     return req;
    endfunction

endpackage

// File: rtl/vtg_line_ctr.sv
module vtg_line_ctr
    import vtg_pkg::*;
#(
    parameter int HW     = 10,
    parameter int LINE_A = 864,
    parameter int LINE_B = 858,
    parameter int HWIN   = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  vtg_std_e      std,
    input  logic          sync_en,
    input  logic          line_stb,
    output logic [HW-1:0] h_cnt,
    output logic          line_adv
);

    logic [HW-1:0] ll_last;
    logic [HW-1:0] h_nxt;
    logic          near_start;
    logic          near_end;
    logic          accept;

    always_comb begin
        ll_last    = (std == STD_525) ? HW'(LINE_B - 1) : HW'(LINE_A - 1);
        near_start = (h_cnt <= HW'(HWIN));
        near_end   = (h_cnt >= ll_last - HW'(HWIN - 1));
        accept     = sync_en && line_stb && (near_start || near_end);
        if (accept) begin
            h_nxt    = HW'(1);
            line_adv = near_end;
        end else if (h_cnt >= ll_last) begin
            h_nxt    = '0;
            line_adv = 1'b1;
        end else begin
            h_nxt    = h_cnt + 1'b1;
            line_adv = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) h_cnt <= '0;
        else     h_cnt <= h_nxt;
    end

    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!sync_en && h_cnt == ll_last) |=> (h_cnt == '0)); // R2

    AST_LOCK_RECENTER: assert property (@(posedge clk) disable iff (rst)
        (sync_en && line_stb && int'(h_cnt) <= HWIN) |=> (h_cnt == HW'(1))); // R8

    AST_LOCK_REJECT: assert property (@(posedge clk) disable iff (rst)
        (line_stb && int'(h_cnt) > HWIN && int'(h_cnt) + HWIN < int'(ll_last))
        |=> (int'(h_cnt) == int'($past(h_cnt)) + 1)); // R9

endmodule

// File: rtl/vtg_field_ctr.sv
module vtg_field_ctr
    import vtg_pkg::*;
#(
    parameter int VW    = 9,
    parameter int FLD_A = 313,
    parameter int FLD_B = 263,
    parameter int VWIN  = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  vtg_std_e      std,
    input  logic          sync_en,
    input  logic          fld_stb,
    input  logic          line_adv,
    output logic [VW-1:0] v_cnt
);

    localparam int FLD_MAX = vtg_max(FLD_A, FLD_B);

    logic          odd;
    logic          pend;
    logic [VW-1:0] fl_last;
    logic          accept;
    logic          take;

    always_comb begin
        fl_last = ((std == STD_525) ? VW'(FLD_B - 1) : VW'(FLD_A - 1)) - VW'(odd);
        accept  = sync_en && fld_stb &&
                  ((v_cnt >= fl_last - VW'(VWIN - 1)) || (v_cnt < VW'(VWIN)));
        take    = line_adv && (pend || accept);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_cnt <= '0;
            odd   <= 1'b0;
            pend  <= 1'b0;
        end else begin
            if (line_adv) begin
                pend <= 1'b0;
                if (take) begin
                    v_cnt <= '0;
                    if (v_cnt >= VW'(VWIN)) odd <= ~odd;
                end else if (v_cnt >= fl_last) begin
                    v_cnt <= '0;
                    odd   <= ~odd;
                end else begin
                    v_cnt <= v_cnt + 1'b1;
                end
            end else if (accept) begin
                pend <= 1'b1;
            end
        end
    end

    AST_FIELD_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(v_cnt) < FLD_MAX); // R3

    AST_FIELD_TAKE: assert property (@(posedge clk) disable iff (rst)
        (line_adv && pend) |=> (v_cnt == '0)); // R10

    AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!line_adv) |=> $stable(v_cnt)); // R3

endmodule

// File: rtl/vtg_out_shape.sv
module vtg_out_shape
    import vtg_pkg::*;
#(
    parameter int HW        = 10,
    parameter int VW        = 9,
    parameter int HGAP      = 64,
    parameter int ACT_FIRST = 22,
    parameter int ACT_A     = 288,
    parameter int ACT_B     = 240
) (
    input  logic          clk,
    input  logic          rst,
    input  vtg_std_e      std,
    input  logic [HW-1:0] h_cnt,
    input  logic [VW-1:0] v_cnt,
    input  logic [3:0]    vlen,
    input  logic          hpol,
    input  logic          vpol,
    output logic          href_o,
    output logic          vref_o,
    output logic          vact_o
);

    localparam logic [VW-1:0] ACT_LO   = VW'(ACT_FIRST);
    localparam logic [VW-1:0] ACT_HI_A = VW'(ACT_FIRST + ACT_A);
    localparam logic [VW-1:0] ACT_HI_B = VW'(ACT_FIRST + ACT_B);

    vtg_ref_t      act_d;
    vtg_ref_t      act_q;
    logic [1:0]    pol_q;
    logic [3:0]    vl;
    logic [VW-1:0] act_hi;

    always_comb begin
        vl         = vtg_vlen_clamp(vlen);
        act_hi     = (std == STD_525) ? ACT_HI_B : ACT_HI_A;
        act_d.href = (h_cnt >= HW'(HGAP));
        act_d.vref = (v_cnt < VW'(vl));
        act_d.vact = act_d.href && (v_cnt >= ACT_LO) && (v_cnt < act_hi);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            pol_q <= '0;
        end else begin
            act_q <= act_d;
            pol_q <= {hpol, vpol};
        end
    end

    assign href_o = act_q.href ^ pol_q[1];
    assign vref_o = act_q.vref ^ pol_q[0];
    assign vact_o = act_q.vact;

    AST_VACT_WINDOW: assert property (@(posedge clk) disable iff (rst)
        act_q.vact |-> (int'($past(h_cnt)) >= HGAP && int'($past(v_cnt)) >= ACT_FIRST)); // R6

    AST_VREF_CEIL: assert property (@(posedge clk) disable iff (rst)
        act_q.vref |-> (int'($past(v_cnt)) < 9)); // R5

    AST_VREF_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && int'($past(v_cnt)) < 2) |-> act_q.vref); // R5

endmodule

// File: rtl/vtg_timing_gen.sv
module vtg_timing_gen
    import vtg_pkg::*;
#(
    parameter int LINE_A    = 864,
    parameter int LINE_B    = 858,
    parameter int FLD_A     = 313,
    parameter int FLD_B     = 263,
    parameter int HGAP      = 64,
    parameter int ACT_FIRST = 22,
    parameter int ACT_A     = 288,
    parameter int ACT_B     = 240,
    parameter int HWIN      = 8,
    parameter int VWIN      = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       std_sel,
    input  logic       sync_en,
    input  logic       line_stb,
    input  logic       fld_stb,
    input  logic [3:0] vlen,
    input  logic       hpol,
    input  logic       vpol,
    output logic       href,
    output logic       vref,
    output logic       vact
);

    localparam int HW = $clog2(vtg_max(LINE_A, LINE_B));
    localparam int VW = vtg_max($clog2(vtg_max(FLD_A, FLD_B)), 4);

    vtg_std_e      std;
    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic          line_adv;

    assign std = vtg_std_e'(std_sel);

    vtg_line_ctr #(
        .HW(HW), .LINE_A(LINE_A), .LINE_B(LINE_B), .HWIN(HWIN)
    ) u_line (
        .clk(clk), .rst(rst), .std(std), .sync_en(sync_en),
        .line_stb(line_stb), .h_cnt(h_cnt), .line_adv(line_adv)
    );

    vtg_field_ctr #(
        .VW(VW), .FLD_A(FLD_A), .FLD_B(FLD_B), .VWIN(VWIN)
    ) u_field (
        .clk(clk), .rst(rst), .std(std), .sync_en(sync_en),
        .fld_stb(fld_stb), .line_adv(line_adv), .v_cnt(v_cnt)
    );

    vtg_out_shape #(
        .HW(HW), .VW(VW), .HGAP(HGAP), .ACT_FIRST(ACT_FIRST),
        .ACT_A(ACT_A), .ACT_B(ACT_B)
    ) u_shape (
        .clk(clk), .rst(rst), .std(std), .h_cnt(h_cnt), .v_cnt(v_cnt),
        .vlen(vlen), .hpol(hpol), .vpol(vpol),
        .href_o(href), .vref_o(vref), .vact_o(vact)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!href && !vref && !vact)); // R1

endmodule

// File: tb/vtg_timing_gen_tb.sv
module vtg_timing_gen_tb;

    localparam int LA = 100;
    localparam int LB = 94;
    localparam int FA = 13;
    localparam int FB = 11;
    localparam int GAP = 16;
    localparam int AF = 3;
    localparam int AA = 8;
    localparam int AB = 6;
    localparam int HW_ = 8;
    localparam int VW_ = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic std_sel = 1'b0;
    logic sync_en = 1'b0;
    logic line_stb = 1'b0;
    logic fld_stb = 1'b0;
    logic [3:0] vlen = 4'd5;
    logic hpol = 1'b0;
    logic vpol = 1'b0;
    logic href, vref, vact;

    always #5 clk = ~clk;

    vtg_timing_gen #(
        .LINE_A(LA), .LINE_B(LB), .FLD_A(FA), .FLD_B(FB), .HGAP(GAP),
        .ACT_FIRST(AF), .ACT_A(AA), .ACT_B(AB), .HWIN(HW_), .VWIN(VW_)
    ) u_dut (
        .clk(clk), .rst(rst), .std_sel(std_sel), .sync_en(sync_en),
        .line_stb(line_stb), .fld_stb(fld_stb), .vlen(vlen),
        .hpol(hpol), .vpol(vpol), .href(href), .vref(vref), .vact(vact)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 0;
    string tag = "R1";

    // behavioural reference
    int hc = 0, vc = 0, par = 0, pend = 0;
    bit e_h = 0, e_v = 0, e_a = 0;

    always @(posedge clk) begin
        int ll, fl, L, nact;
        bit adv, lacc, facc;
        if (rst) begin
            hc = 0; vc = 0; par = 0; pend = 0;
            e_h = 0; e_v = 0; e_a = 0;
        end else begin
            ll = std_sel ? LB : LA;
            L = (vlen < 2) ? 2 : ((vlen > 9) ? 9 : int'(vlen));
            nact = std_sel ? AB : AA;
            e_h = (hc >= GAP) ^ hpol;
            e_v = (vc < L) ^ vpol;
            e_a = (hc >= GAP) && (vc >= AF) && (vc < AF + nact);
            fl = (std_sel ? FB : FA) - par;
            lacc = sync_en && line_stb && (hc <= HW_ || hc >= ll - HW_);
            facc = sync_en && fld_stb && (vc >= fl - VW_ || vc < VW_);
            adv = 0;
            if (lacc) begin
                adv = (hc >= ll - HW_);
                hc = 1;
            end else if (hc >= ll - 1) begin
                hc = 0;
                adv = 1;
            end else begin
                hc = hc + 1;
            end
            if (adv) begin
                if (pend != 0 || facc) begin
                    if (vc >= VW_) par = 1 - par;
                    vc = 0;
                end else if (vc >= fl - 1) begin
                    vc = 0;
                    par = 1 - par;
                end else begin
                    vc = vc + 1;
                end
                pend = 0;
            end else if (facc) begin
                pend = 1;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            n_cmp += 3;
            if (href !== e_h) begin
                n_bad++;
                $display("FAIL R2/%s href act=%b exp=%b t=%0t", tag, href, e_h, $time);
            end
            if (vref !== e_v) begin
                n_bad++;
                $display("FAIL R4/%s vref act=%b exp=%b t=%0t", tag, vref, e_v, $time);
            end
            if (vact !== e_a) begin
                n_bad++;
                $display("FAIL R6/%s vact act=%b exp=%b t=%0t", tag, vact, e_a, $time);
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_line(input int pos);
        @(negedge clk);
        while (hc != pos) @(negedge clk);
        line_stb = 1'b1;
        @(negedge clk);
        line_stb = 1'b0;
        run(3 * LA);
    endtask

    task automatic pulse_field(input int vpos);
        @(negedge clk);
        while (!(vc == vpos && hc == 40)) @(negedge clk);
        fld_stb = 1'b1;
        @(negedge clk);
        fld_stb = 1'b0;
        run(2 * FA * LA);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired act=running exp=done");
        finish_run();
    end

    initial begin
        @(posedge clk);
        cmp_on = 1;
        // R1: outputs quiet during reset
        repeat (4) begin
            @(negedge clk);
            n_cmp++;
            if ({href, vref, vact} !== 3'b000) begin
                n_bad++;
                $display("FAIL R1 reset outputs act=%b exp=000", {href, vref, vact});
            end
        end
        rst = 1'b0;

        tag = "R3";   // free run, 625-line, two frames
        run(2 * (FA + FA - 1) * LA + 50);

        tag = "R5";
        vlen = 4'd0;  run((2 * FA) * LA);
        vlen = 4'd1;  run(FA * LA);
        vlen = 4'd15; run((2 * FA) * LA);
        vlen = 4'd9;  run(FA * LA);

        tag = "R7";
        hpol = 1'b1; vpol = 1'b1; run(FA * LA);
        hpol = 1'b0; run(3 * LA);
        vpol = 1'b0; hpol = 1'b1; run(3 * LA);
        hpol = 1'b0;

        tag = "R3";   // switch to 525-line mid-run
        std_sel = 1'b1;
        vlen = 4'd4;
        run(2 * (FB + FB - 1) * LB + 70);

        tag = "R8";
        sync_en = 1'b1;
        pulse_line(LB - 3);
        pulse_line(5);
        pulse_line(HW_);
        pulse_line(LB - HW_);
        pulse_line(0);

        tag = "R9";
        pulse_line(20);
        pulse_line(HW_ + 1);
        pulse_line(LB - HW_ - 1);
        sync_en = 1'b0;
        pulse_line(3);
        sync_en = 1'b1;

        tag = "R10";
        pulse_field(FB - 2);
        pulse_field(1);
        pulse_field(6);
        pulse_field(VW_);
        std_sel = 1'b0;
        pulse_field(FA - VW_);
        sync_en = 1'b0;
        pulse_field(0);

        tag = "R6";
        run(2 * FA * LA);

        finish_run();
    end

endmodule